// File: doc/BRIEF.md
# Pipelined Burst SRAM with Byte-Lane Writes

This block is a synchronous single-port memory with one register stage on the way in and one on the way out. Each word is 32 bits wide and made of four byte lanes. An access starts when one of two load strobes is sampled low on a rising clock edge. That edge captures the address, the write controls and the write data. A read returns its word on the data-out port one clock later.

Once an access is loaded, the block can run a four-beat burst. On each edge where the step input is low, a two-bit counter moves the low address bits forward, in either linear or interleaved order. On an edge where the step input is high, the current address is accessed again.

Writes are either whole-word (global write) or lane-masked (byte writes with per-lane selects). The data bus is modelled as a data-out port plus a drive-enable. The drive-enable is gated without a clock by an active-low output enable and by a sleep input. Sleep freezes all traffic and keeps the memory contents.

Top module: `psb_sram`

## Requirements
- R1: A load happens on a rising edge when `cpu_ld_n` is low with `sel_a_n` low, or when `ctl_ld_n` is low. The load selects the device only if `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. A selected load with `wr_all_n`=1 and `wr_byte_n`=1 is a read of `addr`.
- R2: When a read is sampled on edge k, the word stored at the accessed address is on `rdata` and `rdata_oe` is 1 from edge k+1 until edge k+2, provided `out_en_n` is 0 and `sleep` is 0.
- R3: A load that deselects performs no access. `rdata_oe` is 0 in the cycle after the next edge and stays 0 until a later read's output slot. In particular it is 0 in the first cycle after a read is loaded from the deselected state.
- R4: `out_en_n`=1 forces `rdata_oe` to 0 in the same cycle, with no clock edge needed. Returning it to 0 restores driving of valid read data.
- R5: `wr_all_n`=0 marks the access as a write of all four lanes, whatever `wr_byte_n` and `lane_sel_n` are.
- R6: With `wr_all_n`=1 and `wr_byte_n`=0, lane i (`wdata[8i+7:8i]`) is written only when `lane_sel_n[i]`=0. Unselected lanes keep their old contents, and a write with no lane selected changes nothing.
- R7: While `sleep` is 1, `rdata_oe` is 0 and loads, bursts, reads and writes have no effect. Sleep ends any burst, `rdata_oe` is 0 in the first cycle after `sleep` falls, and memory contents are kept.
- R8: The address of burst beat n (the beat counter wraps modulo 4) keeps `addr[5:2]` of the start address. Its low two bits are start+n modulo 4 when `burst_lin`=1, and start XOR n when `burst_lin`=0.
- R9: During an active burst, an edge with no load and `step_n`=1 accesses the current burst address again without advancing.
- R10: `cpu_ld_n` low while `sel_a_n` is 1 is ignored, so a running burst goes on. `ctl_ld_n` low while `sel_a_n` is 1 loads and deselects.
- R11: During a burst, each edge that carries a write request writes the current burst address using the data and lane mask sampled on that edge.
- R12: After synchronous reset no burst is active and `rdata_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| sel_a_n | input | 1 | Chip select A, active low; also qualifies `cpu_ld_n` |
| sel_b | input | 1 | Chip select B, active high |
| sel_c_n | input | 1 | Chip select C, active low |
| cpu_ld_n | input | 1 | Load strobe, honoured only with `sel_a_n` low |
| ctl_ld_n | input | 1 | Load strobe, always honoured |
| step_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Whole-word write, active low |
| wr_byte_n | input | 1 | Lane-masked write enable, active low |
| lane_sel_n | input | 4 | Per-lane write selects, active low |
| out_en_n | input | 1 | Output enable, active low, acts without a clock |
| sleep | input | 1 | Sleep request, active high |
| burst_lin | input | 1 | Burst order: 1 linear, 0 interleaved |
| addr | input | 6 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| rdata_oe | output | 1 | Bus drive enable for `rdata` |

## Verification
Two behaviours can overlap in one cycle: a read word is due on the bus while the sleep input or the output enable changes. The bench provokes both during a running burst. It raises sleep in the cycle where a beat's data is being driven, and separately toggles the output enable mid-slot. In each case it checks that the drive-enable drops at once, that no access issued during sleep reaches memory, and that the driven word is correct again once the enable returns. Deselects and ignored strobes are also issued in the middle of a running burst. The bench then checks whether the bus keeps following the burst order or goes quiet two edges later.

// File: rtl/psb_pkg.sv
package psb_pkg;
  localparam int BURST_W = 2;

  function automatic logic [BURST_W-1:0] burst_offset(
    input logic [BURST_W-1:0] start,
    input logic [BURST_W-1:0] beat,
    input logic               lin
  );
    return lin ? (start + beat) : (start ^ beat);
  endfunction
endpackage

// File: rtl/psb_addr_gen.sv
module psb_addr_gen
  import psb_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear_i,
  input  logic          load_i,
  input  logic          load_sel_i,
  input  logic [AW-1:0] addr_i,
  input  logic          step_i,
  input  logic          lin_i,
  output logic [AW-1:0] acc_addr_o,
  output logic          active_o
);
  logic [AW-1:0]      base_q;
  logic [BURST_W-1:0] cnt_q;
  logic [BURST_W-1:0] cnt_nxt;
  logic               act_q;

  assign cnt_nxt  = cnt_q + BURST_W'(step_i);
  assign active_o = act_q;

  always_comb begin
    if (load_i) acc_addr_o = addr_i;
    else        acc_addr_o = {base_q[AW-1:BURST_W],
                              burst_offset(base_q[BURST_W-1:0], cnt_nxt, lin_i)};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      cnt_q  <= '0;
      base_q <= '0;
    end else if (clear_i) begin
      act_q <= 1'b0;
    end else if (load_i) begin
      base_q <= addr_i;
      cnt_q  <= '0;
      act_q  <= load_sel_i;
    end else if (act_q) begin
      cnt_q <= cnt_nxt;
    end
  end

  // R8: the burst start address stays fixed while a burst runs
  a_r8_base_held: assert property (@(posedge clk) disable iff (rst)
    (act_q && !load_i) |=> (base_q == $past(base_q)));
endmodule

// File: rtl/psb_mem_core.sv
module psb_mem_core #(
  parameter int AW    = 6,
  parameter int LANES = 4,
  parameter int LW    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we_i,
  input  logic                re_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [LANES-1:0]    wmask_i,
  input  logic [LANES*LW-1:0] wdata_i,
  output logic [LANES*LW-1:0] rdata_o,
  output logic                rvalid_o
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] ram [DEPTH];
    logic [LW-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (we_i && wmask_i[g]) ram[addr_i] <= wdata_i[g*LW +: LW];
    end

    always_ff @(posedge clk) begin
      if (re_i) rd_q <= ram[addr_i];
    end

    assign rdata_o[g*LW +: LW] = rd_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rvalid_o <= 1'b0;
    else     rvalid_o <= re_i;
  end

  // R1: a single access slot per cycle, never read and write together
  a_r1_single_port: assert property (@(posedge clk) disable iff (rst)
    !(we_i && re_i));
endmodule

// File: rtl/psb_sram.sv
module psb_sram
  import psb_pkg::*;
#(
  parameter int AW    = 6,
  parameter int LANES = 4,
  parameter int LW    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sel_a_n,
  input  logic                sel_b,
  input  logic                sel_c_n,
  input  logic                cpu_ld_n,
  input  logic                ctl_ld_n,
  input  logic                step_n,
  input  logic                wr_all_n,
  input  logic                wr_byte_n,
  input  logic [LANES-1:0]    lane_sel_n,
  input  logic                out_en_n,
  input  logic                sleep,
  input  logic                burst_lin,
  input  logic [AW-1:0]       addr,
  input  logic [LANES*LW-1:0] wdata,
  output logic [LANES*LW-1:0] rdata,
  output logic                rdata_oe
);
  localparam int DW = LANES * LW;

  logic             ld, sel_ok, wr_req, go, step, active, rd_valid;
  logic [LANES-1:0] mask;
  logic [AW-1:0]    acc_addr;

  logic             acc_v_q, acc_wr_q;
  logic [AW-1:0]    acc_addr_q;
  logic [DW-1:0]    acc_data_q;
  logic [LANES-1:0] acc_mask_q;

  assign ld     = ~sleep & ((~cpu_ld_n & ~sel_a_n) | ~ctl_ld_n);
  assign sel_ok = ~sel_a_n & sel_b & ~sel_c_n;
  assign wr_req = ~wr_all_n | ~wr_byte_n;
  assign go     = ~sleep & (ld ? sel_ok : active);
  assign step   = ~ld & ~step_n;

  always_comb begin
    if (!wr_all_n)       mask = '1;
    else if (!wr_byte_n) mask = ~lane_sel_n;
    else                 mask = '0;
  end

  psb_addr_gen #(.AW(AW)) u_agen (
    .clk        (clk),
    .rst        (rst),
    .clear_i    (sleep),
    .load_i     (ld),
    .load_sel_i (sel_ok),
    .addr_i     (addr),
    .step_i     (step),
    .lin_i      (burst_lin),
    .acc_addr_o (acc_addr),
    .active_o   (active)
  );

  always_ff @(posedge clk) begin
    if (rst) acc_v_q <= 1'b0;
    else     acc_v_q <= go;
  end

  always_ff @(posedge clk) begin
    acc_wr_q   <= wr_req;
    acc_addr_q <= acc_addr;
    acc_data_q <= wdata;
    acc_mask_q <= mask;
  end

  psb_mem_core #(.AW(AW), .LANES(LANES), .LW(LW)) u_mem (
    .clk      (clk),
    .rst      (rst),
    .we_i     (acc_v_q & acc_wr_q & ~sleep),
    .re_i     (acc_v_q & ~acc_wr_q & ~sleep),
    .addr_i   (acc_addr_q),
    .wmask_i  (acc_mask_q),
    .wdata_i  (acc_data_q),
    .rdata_o  (rdata),
    .rvalid_o (rd_valid)
  );

  assign rdata_oe = rd_valid & ~out_en_n & ~sleep;

  // R2: an accepted read owns the output slot one edge later
  a_r2_read_slot: assert property (@(posedge clk) disable iff (rst)
    (acc_v_q && !acc_wr_q && !sleep) |=> rd_valid);

  // R3: a deselecting load leaves the output slot two edges later empty
  a_r3_desel_gap: assert property (@(posedge clk) disable iff (rst)
    (ld && !sel_ok) |=> ##1 !rd_valid);

  // R7: the bus is undriven in the first cycle after sleep ends
  a_r7_wake_quiet: assert property (@(posedge clk) disable iff (rst)
    $fell(sleep) |-> !rdata_oe);
endmodule

// File: tb/tb_psb_sram.sv
module tb_psb_sram;
  logic        clk = 1'b0;
  logic        rst;
  logic        sel_a_n, sel_b, sel_c_n, cpu_ld_n, ctl_ld_n, step_n;
  logic        wr_all_n, wr_byte_n, out_en_n, sleep, burst_lin;
  logic [3:0]  lane_sel_n;
  logic [5:0]  addr;
  logic [31:0] wdata, rdata;
  logic        rdata_oe;

  int n_chk = 0;
  int n_err = 0;
  logic [31:0] model [64];

  always #4 clk = ~clk;

  psb_sram dut (
    .clk(clk), .rst(rst), .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .cpu_ld_n(cpu_ld_n), .ctl_ld_n(ctl_ld_n), .step_n(step_n),
    .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_sel_n(lane_sel_n),
    .out_en_n(out_en_n), .sleep(sleep), .burst_lin(burst_lin),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  // {wr_all_n, wr_byte_n, lane_sel_n, addr, wdata}
  localparam logic [43:0] VEC [10] = '{
    {1'b0, 1'b1, 4'hF, 6'h03, 32'h11223344},
    {1'b0, 1'b0, 4'hF, 6'h04, 32'h55667788},
    {1'b1, 1'b0, 4'hE, 6'h03, 32'hAAAAAAAA},
    {1'b1, 1'b0, 4'h5, 6'h04, 32'hCCDDEEFF},
    {1'b1, 1'b0, 4'hF, 6'h05, 32'h99999999},
    {1'b0, 1'b1, 4'h0, 6'h3F, 32'hDEADBEEF},
    {1'b1, 1'b0, 4'h0, 6'h00, 32'h0BADF00D},
    {1'b1, 1'b0, 4'h7, 6'h3F, 32'h12345678},
    {1'b0, 1'b0, 4'h6, 6'h05, 32'hFEDCBA98},
    {1'b1, 1'b0, 4'hB, 6'h00, 32'h55AA55AA}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    cpu_ld_n = 1'b1; ctl_ld_n = 1'b1; step_n = 1'b1;
    wr_all_n = 1'b1; wr_byte_n = 1'b1; lane_sel_n = 4'hF;
    sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
  endtask

  task automatic model_wr(input logic [5:0] a, input logic [31:0] d, input logic [3:0] m);
    for (int l = 0; l < 4; l++) if (m[l]) model[a][l*8 +: 8] = d[l*8 +: 8];
  endtask

  task automatic do_write(input logic [5:0] a, input logic [31:0] d,
                          input logic gwn, input logic bwen, input logic [3:0] lsn);
    @(negedge clk); idle(); ctl_ld_n = 1'b0; addr = a; wdata = d;
    wr_all_n = gwn; wr_byte_n = bwen; lane_sel_n = lsn;
    @(negedge clk); idle(); ctl_ld_n = 1'b0; sel_b = 1'b0;
    @(negedge clk); idle();
    model_wr(a, d, !gwn ? 4'hF : (!bwen ? ~lsn : 4'h0));
  endtask

  // Read burst of n beats from start; stepm[i] = advance on drive i; ign = poke ignored strobe
  task automatic burst_chk(input logic [5:0] start, input logic lin, input logic [7:0] stepm,
                           input int n, input logic ign, input string req);
    logic [5:0] ea [8];
    logic [1:0] c;
    c = 2'd0;
    for (int j = 0; j < n; j++) begin
      ea[j] = {start[5:2], lin ? start[1:0] + c : start[1:0] ^ c};
      if (j < n - 1 && stepm[j]) c = c + 2'd1;
    end
    @(negedge clk); idle(); ctl_ld_n = 1'b0; addr = start; burst_lin = lin;
    for (int i = 0; i <= n; i++) begin
      @(negedge clk);
      if (i == 0) chk("R3", {31'd0, rdata_oe}, 32'd0);
      else begin
        chk(req, {31'd0, rdata_oe}, 32'd1);
        chk(req, rdata, model[ea[i-1]]);
      end
      idle(); burst_lin = lin;
      if (i < n - 1) begin
        step_n = ~stepm[i];
        if (ign) begin cpu_ld_n = 1'b0; sel_a_n = 1'b1; end
      end else if (i == n - 1) begin
        ctl_ld_n = 1'b0;
        if (ign) sel_a_n = 1'b1; else sel_b = 1'b0;
      end
    end
    @(negedge clk);
    chk(ign ? "R10" : "R3", {31'd0, rdata_oe}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R12 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1; idle(); out_en_n = 1'b0; sleep = 1'b0; burst_lin = 1'b1;
    addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    chk("R12", {31'd0, rdata_oe}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R12", {31'd0, rdata_oe}, 32'd0);

    for (int a = 0; a < 64; a++) begin
      model[a] = 32'h0;
      do_write(6'(a), {2'b00, 6'(a), 2'b01, 6'(a), 2'b10, 6'(a), 2'b11, 6'(a)}, 1'b0, 1'b1, 4'hF);
    end

    // Vector table: lane-masked and global writes, then readback
    for (int v = 0; v < 10; v++)
      do_write(VEC[v][37:32], VEC[v][31:0], VEC[v][43], VEC[v][42], VEC[v][41:38]);
    for (int v = 0; v < 10; v++)
      burst_chk(VEC[v][37:32], 1'b1, 8'h00, 1, 1'b0, VEC[v][43] ? "R6" : "R5");

    burst_chk(6'h3F, 1'b0, 8'h00, 1, 1'b0, "R1");
    burst_chk(6'h11, 1'b1, 8'hFF, 5, 1'b0, "R8");
    burst_chk(6'h11, 1'b0, 8'hFF, 4, 1'b0, "R8");
    burst_chk(6'h2E, 1'b1, 8'h09, 5, 1'b0, "R9");
    burst_chk(6'h11, 1'b1, 8'hFF, 4, 1'b1, "R10");

    // R11: write burst, interleaved, masks sampled per beat
    @(negedge clk); idle(); ctl_ld_n = 1'b0; addr = 6'h21; burst_lin = 1'b0;
    wr_all_n = 1'b0; wdata = 32'h0F0F0F0F;
    model_wr(6'h21, 32'h0F0F0F0F, 4'hF);
    for (int k = 1; k < 4; k++) begin
      logic [3:0] m;
      m = (k == 1) ? 4'b0011 : (k == 2) ? 4'b1100 : 4'b1001;
      @(negedge clk); idle(); burst_lin = 1'b0; step_n = 1'b0; wr_byte_n = 1'b0;
      lane_sel_n = ~m; wdata = 32'hA1B2C3D0 + 32'(k);
      model_wr({4'h8, 2'b01 ^ 2'(k)}, 32'hA1B2C3D0 + 32'(k), m);
    end
    @(negedge clk); idle(); ctl_ld_n = 1'b0; sel_b = 1'b0;
    @(negedge clk); idle();
    burst_chk(6'h21, 1'b0, 8'hFF, 4, 1'b0, "R11");

    // R7: sleep raised while a burst beat is on the bus
    @(negedge clk); idle(); ctl_ld_n = 1'b0; addr = 6'h11; burst_lin = 1'b1;
    @(negedge clk); idle(); step_n = 1'b0;
    @(negedge clk);
    chk("R2", {31'd0, rdata_oe}, 32'd1);
    chk("R2", rdata, model[6'h11]);
    sleep = 1'b1; #1;
    chk("R7", {31'd0, rdata_oe}, 32'd0);
    idle(); ctl_ld_n = 1'b0; addr = 6'h11; wr_all_n = 1'b0; wdata = 32'hFFFFFFFF;
    @(negedge clk);
    @(negedge clk); sleep = 1'b0; idle(); step_n = 1'b0; #1;
    chk("R7", {31'd0, rdata_oe}, 32'd0);
    @(negedge clk);
    chk("R7", {31'd0, rdata_oe}, 32'd0);
    idle();
    burst_chk(6'h11, 1'b1, 8'h00, 1, 1'b0, "R7");

    // R4: output enable toggled mid-slot
    @(negedge clk); idle(); ctl_ld_n = 1'b0; addr = 6'h03;
    @(negedge clk); idle();
    @(negedge clk);
    chk("R2", {31'd0, rdata_oe}, 32'd1);
    out_en_n = 1'b1; #1;
    chk("R4", {31'd0, rdata_oe}, 32'd0);
    out_en_n = 1'b0; #1;
    chk("R4", {31'd0, rdata_oe}, 32'd1);
    chk("R4", rdata, model[6'h03]);
    idle(); ctl_ld_n = 1'b0; sel_c_n = 1'b1;
    @(negedge clk); idle();
    @(negedge clk);
    chk("R3", {31'd0, rdata_oe}, 32'd0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule